// File: doc/BRIEF.md
# PCM Highway Receive Slot Extractor

This block pulls one channel's receive sample off a serial time-division PCM highway. The highway brings in a bit clock, a frame-sync pulse and two serial data lines. All of them are asynchronous to the system clock. The block synchronizes these inputs into the system clock domain and detects each falling edge of the bit clock. On every such edge it counts the bit position within the frame, starting from the frame-sync pulse.

A time-slot number and a skew value pick the bit where capture starts. The skew value is a bit-level delay of 0 to 7 bit clocks added to the slot start. In compressed mode the block captures one 8-bit slot. In linear mode it captures a 16-bit two's-complement word spread over two adjacent slots. The word arrives sign bit first.

A port-select bit chooses which serial line feeds the capture. The captured value leaves the block with a one-cycle strobe and a flag that gives the mode. A window that the next frame sync cuts short never produces a strobe. For that reason, on a frame whose bit count is not a multiple of eight, the last slot is lost when the skew exceeds that remainder.

Top module: `pcm_rx_slot`

## Requirements
- R1: The bit sampled on the bit-clock falling edge where frame sync is high is frame bit 0. Slot k covers bits 8k to 8k+7, and the first bit received in the window is the most significant bit of the result.
- R2: The capture window starts at bit 8*slot + skew, where the skew value is 0 to 7.
- R3: In compressed mode (cfg_linear = 0), 8 bits are captured. They appear on rx_data[7:0], rx_data[15:8] reads zero, and rx_linear is 0.
- R4: In linear mode (cfg_linear = 1), 16 bits from two consecutive slots are captured. The first received bit is rx_data[15], and rx_linear is 1.
- R5: With cfg_port_b = 0 the data comes from pcm_din_a. With cfg_port_b = 1 it comes from pcm_din_b.
- R6: Slot, skew, mode and port select are taken on the frame-sync bit. A change to them within a frame has no effect on that frame's capture.
- R7: When the frame ends before the last bit of the window (next frame sync first), no strobe is issued for that frame. For example, in a 193-bit frame, slot 23 is received with skew 1 and is lost with skew 2.
- R8: After reset rx_valid, rx_data and rx_linear are 0. No strobe is issued before the first frame sync.
- R9: rx_valid is a single system-clock pulse. rx_data and rx_linear change only together with it and hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pcm_clk | input | 1 | Highway bit clock, asynchronous |
| pcm_fs | input | 1 | Frame-sync pulse, high during bit 0 |
| pcm_din_a | input | 1 | Serial data line A |
| pcm_din_b | input | 1 | Serial data line B |
| cfg_slot | input | 7 | Assigned time slot |
| cfg_skew | input | 3 | Bit-clock delay added to the slot start |
| cfg_linear | input | 1 | 1 = 16-bit linear, 0 = 8-bit compressed |
| cfg_port_b | input | 1 | 1 = use line B, 0 = use line A |
| rx_data | output | 16 | Captured sample |
| rx_valid | output | 1 | One-cycle strobe for a new sample |
| rx_linear | output | 1 | Mode of the sample on rx_data |

## Verification
A strobe is due SYNC_STAGES + 2 system clocks after the bit-clock falling edge that carries the last window bit. That is two synchronizer stages, then the position register, then the capture register. The bench holds each bit for eight system clocks, which is longer than this latency, so every strobe arrives before the next bit could start another window. The scoreboard therefore pairs strobes with expectations by order rather than by cycle count. The driver queues an expectation only when the window closes inside the frame. A lost slot therefore shows up either as an unmatched strobe or as a queue that is not empty after a 20-cycle drain at the end.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic {
    MODE_COMPRESSED = 1'b0,
    MODE_LINEAR     = 1'b1
  } pcm_mode_e;

  localparam int LANE_CLK = 0;
  localparam int LANE_FS  = 1;
  localparam int LANE_A   = 2;
  localparam int LANE_B   = 3;
  localparam int LANES    = 4;
endpackage

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int LANES       = 4,
  parameter int CLK_LANE    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] smp,
  output logic             fall_stb
);
  logic [LANES-1:0] stg [SYNC_STAGES];
  logic             clk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
      clk_prev <= 1'b0;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      clk_prev <= stg[SYNC_STAGES-1][CLK_LANE];
    end
  end

  assign smp      = stg[SYNC_STAGES-1];
  assign fall_stb = clk_prev & ~stg[SYNC_STAGES-1][CLK_LANE];
endmodule

// File: rtl/pcm_rx_frame_ctr.sv
module pcm_rx_frame_ctr #(
  parameter int POS_W  = 11,
  parameter int SLOT_W = 7,
  parameter int SKEW_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              fs_bit,
  input  logic              din_a,
  input  logic              din_b,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SKEW_W-1:0] cfg_skew,
  input  logic              cfg_linear,
  input  logic              cfg_port_b,
  output logic              adv_q,
  output logic              bit_q,
  output logic [POS_W-1:0]  pos_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SKEW_W-1:0] skew_q,
  output pcm_rx_pkg::pcm_mode_e mode_q
);
  import pcm_rx_pkg::*;

  localparam logic [POS_W-1:0] POS_PARK = '1;

  logic port_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_q    <= 1'b0;
      bit_q    <= 1'b0;
      pos_q    <= POS_PARK;
      slot_q   <= '0;
      skew_q   <= '0;
      mode_q   <= MODE_COMPRESSED;
      port_b_q <= 1'b0;
    end else begin
      adv_q <= bit_stb;
      if (bit_stb) begin
        if (fs_bit) begin
          pos_q    <= '0;
          slot_q   <= cfg_slot;
          skew_q   <= cfg_skew;
          mode_q   <= cfg_linear ? MODE_LINEAR : MODE_COMPRESSED;
          port_b_q <= cfg_port_b;
          bit_q    <= cfg_port_b ? din_b : din_a;
        end else begin
          if (pos_q != POS_PARK) pos_q <= pos_q + POS_W'(1);
          bit_q <= port_b_q ? din_b : din_a;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_slot_cap.sv
module pcm_rx_slot_cap #(
  parameter int POS_W     = 11,
  parameter int SLOT_W    = 7,
  parameter int SKEW_W    = 3,
  parameter int SLOT_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   adv,
  input  logic                   bit_in,
  input  logic [POS_W-1:0]       pos,
  input  logic [SLOT_W-1:0]      slot,
  input  logic [SKEW_W-1:0]      skew,
  input  pcm_rx_pkg::pcm_mode_e  mode,
  output logic [2*SLOT_BITS-1:0] word_q,
  output logic                   valid_q,
  output logic                   linear_q
);
  import pcm_rx_pkg::*;

  localparam int WORD_W = 2 * SLOT_BITS;

  logic [POS_W-1:0]  win_start;
  logic [POS_W-1:0]  win_len;
  logic [POS_W-1:0]  win_last;
  logic              in_win;
  logic [WORD_W-1:0] shreg;

  always_comb begin
    win_start = POS_W'(slot) * POS_W'(SLOT_BITS) + POS_W'(skew);
    win_len   = (mode == MODE_LINEAR) ? POS_W'(WORD_W) : POS_W'(SLOT_BITS);
    win_last  = win_start + win_len - POS_W'(1);
    in_win    = (pos >= win_start) && (pos <= win_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
      linear_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (adv && in_win) begin
        if (pos == win_start) shreg <= {{(WORD_W-1){1'b0}}, bit_in};
        else                  shreg <= {shreg[WORD_W-2:0], bit_in};
        if (pos == win_last) begin
          valid_q  <= 1'b1;
          linear_q <= (mode == MODE_LINEAR);
          if (mode == MODE_LINEAR) word_q <= {shreg[WORD_W-2:0], bit_in};
          else word_q <= {{SLOT_BITS{1'b0}}, shreg[SLOT_BITS-2:0], bit_in};
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int SLOT_W      = 7,
  parameter int SKEW_W      = 3,
  parameter int SLOT_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pcm_clk,
  input  logic                   pcm_fs,
  input  logic                   pcm_din_a,
  input  logic                   pcm_din_b,
  input  logic [SLOT_W-1:0]      cfg_slot,
  input  logic [SKEW_W-1:0]      cfg_skew,
  input  logic                   cfg_linear,
  input  logic                   cfg_port_b,
  output logic [2*SLOT_BITS-1:0] rx_data,
  output logic                   rx_valid,
  output logic                   rx_linear
);
  import pcm_rx_pkg::*;

  localparam int WORD_W = 2 * SLOT_BITS;
  localparam int POS_W  = SLOT_W + $clog2(SLOT_BITS) + 1;

  logic [LANES-1:0] raw_lanes;
  logic [LANES-1:0] smp_lanes;
  logic             fall_stb;
  logic             adv;
  logic             bit_d;
  logic [POS_W-1:0] pos;
  logic [SLOT_W-1:0] slot_l;
  logic [SKEW_W-1:0] skew_l;
  pcm_mode_e        mode_l;

  always_comb begin
    raw_lanes           = '0;
    raw_lanes[LANE_CLK] = pcm_clk;
    raw_lanes[LANE_FS]  = pcm_fs;
    raw_lanes[LANE_A]   = pcm_din_a;
    raw_lanes[LANE_B]   = pcm_din_b;
  end

  pcm_rx_edge #(
    .SYNC_STAGES(SYNC_STAGES), .LANES(LANES), .CLK_LANE(LANE_CLK)
  ) u_edge (
    .clk(clk), .rst(rst), .raw(raw_lanes), .smp(smp_lanes), .fall_stb(fall_stb)
  );

  pcm_rx_frame_ctr #(
    .POS_W(POS_W), .SLOT_W(SLOT_W), .SKEW_W(SKEW_W)
  ) u_ctr (
    .clk(clk), .rst(rst), .bit_stb(fall_stb),
    .fs_bit(smp_lanes[LANE_FS]), .din_a(smp_lanes[LANE_A]), .din_b(smp_lanes[LANE_B]),
    .cfg_slot(cfg_slot), .cfg_skew(cfg_skew), .cfg_linear(cfg_linear),
    .cfg_port_b(cfg_port_b),
    .adv_q(adv), .bit_q(bit_d), .pos_q(pos), .slot_q(slot_l), .skew_q(skew_l),
    .mode_q(mode_l)
  );

  pcm_rx_slot_cap #(
    .POS_W(POS_W), .SLOT_W(SLOT_W), .SKEW_W(SKEW_W), .SLOT_BITS(SLOT_BITS)
  ) u_cap (
    .clk(clk), .rst(rst), .adv(adv), .bit_in(bit_d), .pos(pos),
    .slot(slot_l), .skew(skew_l), .mode(mode_l),
    .word_q(rx_data), .valid_q(rx_valid), .linear_q(rx_linear)
  );
endmodule

// File: rtl/pcm_rx_slot_chk.sv
module pcm_rx_slot_chk #(
  parameter int WORD_W    = 16,
  parameter int SLOT_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_linear
);
  // R9: strobe never lasts two cycles
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9: sample held between strobes
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data));

  // R9: mode flag held between strobes
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_linear));

  // R3: compressed sample has zero upper byte
  p_comp_zero_upper_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_linear) |-> (rx_data[WORD_W-1:SLOT_BITS] == '0));

  // R8: reset leaves the strobe low
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> !rx_valid);
endmodule

bind pcm_rx_slot pcm_rx_slot_chk #(.WORD_W(2*SLOT_BITS), .SLOT_BITS(SLOT_BITS)) u_chk (
  .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .rx_linear(rx_linear)
);

// File: tb/pcm_rx_slot_tb.sv
module pcm_rx_slot_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        pcm_clk = 1'b0, pcm_fs = 1'b0, din_a = 1'b0, din_b = 1'b0;
  logic [6:0]  cfg_slot = '0;
  logic [2:0]  cfg_skew = '0;
  logic        cfg_linear = 1'b0, cfg_port_b = 1'b0;
  logic [15:0] rx_data;
  logic        rx_valid, rx_linear;

  pcm_rx_slot u_dut (
    .clk(clk), .rst(rst), .pcm_clk(pcm_clk), .pcm_fs(pcm_fs),
    .pcm_din_a(din_a), .pcm_din_b(din_b), .cfg_slot(cfg_slot), .cfg_skew(cfg_skew),
    .cfg_linear(cfg_linear), .cfg_port_b(cfg_port_b),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_linear(rx_linear)
  );

  typedef struct {
    logic        lin;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pcm_bit(logic fs, logic a, logic b);
    @(negedge clk);
    pcm_clk = 1'b1; pcm_fs = fs; din_a = a; din_b = b;
    repeat (4) @(negedge clk);
    pcm_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(int nbits, int slot, int skew, bit lin, bit portb,
                       logic [15:0] val, string tag,
                       int chg_bit = -1, int chg_slot = 0, bit chg_sel = 0, bit do_sel = 0);
    int start = slot * 8 + skew;
    int len   = lin ? 16 : 8;
    exp_t e;
    cfg_slot = slot[6:0]; cfg_skew = skew[2:0]; cfg_linear = lin; cfg_port_b = portb;
    if (start + len <= nbits) begin
      e.lin = lin; e.d = lin ? val : {8'h00, val[7:0]}; e.tag = tag;
      sb.push_back(e);
    end
    for (int i = 0; i < nbits; i++) begin
      logic v, fill;
      if (i == chg_bit) begin
        if (do_sel) cfg_port_b = chg_sel;
        else        cfg_slot   = chg_slot[6:0];
      end
      fill = ((i % 3) == 1);
      if (i >= start && i < start + len) begin
        v = val[len-1-(i-start)];
        pcm_bit(i == 0, portb ? ~v : v, portb ? v : ~v);
      end else begin
        pcm_bit(i == 0, fill, ~fill);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7/R8", "unexpected strobe", {15'b0, rx_linear, rx_data}, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk((rx_linear == e.lin) && (rx_data == e.d), e.tag, "captured sample",
            {15'b0, rx_linear, rx_data}, {15'b0, e.lin, e.d});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R8", "reset valid", {31'b0, rx_valid}, 32'h0);
    chk(rx_data == 16'h0, "R8", "reset data", {16'b0, rx_data}, 32'h0);
    chk(rx_linear == 1'b0, "R8", "reset mode", {31'b0, rx_linear}, 32'h0);

    // R8: bits with no frame sync yet, slot 0 configured
    for (int i = 0; i < 40; i++) pcm_bit(1'b0, (i % 2) == 0, (i % 2) == 1);

    frame(256, 3, 0, 1'b0, 1'b0, 16'h00A5, "R1");
    frame(256, 5, 3, 1'b0, 1'b0, 16'h003C, "R2");
    frame(256, 10, 7, 1'b1, 1'b0, 16'h8123, "R4");
    frame(256, 2, 0, 1'b0, 1'b1, 16'h005A, "R5");
    frame(256, 30, 0, 1'b1, 1'b0, 16'hB00C, "R4");
    frame(193, 23, 1, 1'b0, 1'b0, 16'h00C3, "R7");
    frame(193, 23, 2, 1'b0, 1'b0, 16'h0077, "R7");
    frame(256, 31, 0, 1'b1, 1'b0, 16'h1234, "R7");
    frame(256, 4, 0, 1'b0, 1'b0, 16'h0096, "R6", 10, 8, 1'b0, 1'b0);
    frame(256, 6, 0, 1'b0, 1'b1, 16'h0069, "R6", 5, 0, 1'b0, 1'b1);
    frame(16, 0, 0, 1'b0, 1'b0, 16'h0081, "R1");
    frame(16, 0, 0, 1'b1, 1'b0, 16'h7E01, "R4");
    frame(8, 127, 0, 1'b0, 1'b0, 16'h0000, "R7");

    repeat (20) @(negedge clk);
    chk(sb.size() == 0, "R7", "pending expectations", sb.size(), 32'h0);
    chk(rx_data == 16'h7E01, "R9", "held data", {16'b0, rx_data}, 32'h7E01);
    chk(rx_linear == 1'b1, "R9", "held mode", {31'b0, rx_linear}, 32'h1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule